// File: doc/BRIEF.md
# 64-bit Compare Timer with Periodic Re-arm

The block keeps a 64-bit up-counter that software can preset and start, and one 64-bit compare channel. The channel fires once when the running count reaches the programmed value. In the periodic variant, the channel instead moves its own target forward by a programmable step after every hit. A hit latches a sticky status flag, and when the mask bit allows it, that flag drives an interrupt line.

All registers are 32 bits wide and reached through a simple write strobe and a combinational read port. The counter and compare values each occupy a low and a high word. Writes to the counter, compare, step and control registers pass through a fixed synchronization delay before they take effect. Each of those registers owns a sticky write-complete flag, so software can poll for the moment its write has landed and then clear the flag by writing 1.

Top module: `cmptmr_top`

## Requirements
- R1: After reset the counter, compare value, step, control bits, every status flag and the mask read as zero, and `irq_o` is low.
- R2: The counter low word is at 0x100 and the high word at 0x104. Writing one word replaces only that word. Both words read the live count.
- R3: While control bit 8 (run, register 0x240) is set, the counter rises by 1 per cycle, with carry from the low word into the high word. While the bit is clear, the counter holds its value.
- R4: A write to 0x100, 0x104, 0x200, 0x204, 0x208 or 0x240 takes effect exactly 3 clock cycles after the cycle in which it is sampled. Until then, reads return the old value.
- R5: Register 0x110 bit 0 sets when a counter low-word write takes effect, and bit 1 sets when a high-word write takes effect. Writing 1 to a bit clears it. A set in the same cycle wins over the clear.
- R6: Register 0x24C bits 0, 1, 2 and 16 set when writes to compare-low (0x200), compare-high (0x204), step (0x208) and control (0x240) take effect. Each bit is cleared by writing 1 to it, and other bits are untouched.
- R7: A hit occurs when control bit 0 (compare enable) is set, the channel is armed, and the counter equals the compare value. A hit sets status bit 0 of 0x244 at the next clock edge.
- R8: With control bit 1 (periodic) clear, the channel disarms after a hit and the compare value is unchanged. No further hit occurs until a compare word or the control register is written again.
- R9: With control bit 1 set, each hit adds the 32-bit step at 0x208 to the compare value, so hits recur every step cycles while the counter runs.
- R10: The status bit stays set until 1 is written to 0x244 bit 0. Writing 0 there has no effect, and a hit in the same cycle wins over the clear.
- R11: `irq_o` is high exactly when the status bit and the mask bit (0x248 bit 0) are both set. Writes to the mask take effect at the next clock edge.
- R12: `bus_rdata` follows `bus_addr` combinationally. Unmapped addresses read zero, and the control register reads back only bits 8, 1 and 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 12 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_o | output | 1 | Interrupt: status AND mask |

## Verification
The properties assume that `bus_addr` and `bus_wdata` are stable and known whenever `bus_we` is high. They also assume that the counter never wraps through its 64-bit limit within a run. The stimulus changes bus signals only on the falling edge and presets the counter with random values whose high word stays far from all ones. Compare targets are placed a bounded random distance ahead of a stopped counter, so every hit falls inside the observation window.

// File: rtl/cmptmr_pkg.sv
package cmptmr_pkg;

    localparam int WORD_W = 32;
    localparam int CNT_W  = 2 * WORD_W;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] A_CNT_LO = 12'h100;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 12'h104;
    localparam logic [ADDR_W-1:0] A_CNT_WS = 12'h110;
    localparam logic [ADDR_W-1:0] A_CMP_LO = 12'h200;
    localparam logic [ADDR_W-1:0] A_CMP_HI = 12'h204;
    localparam logic [ADDR_W-1:0] A_STEP   = 12'h208;
    localparam logic [ADDR_W-1:0] A_CTRL   = 12'h240;
    localparam logic [ADDR_W-1:0] A_IST    = 12'h244;
    localparam logic [ADDR_W-1:0] A_IEN    = 12'h248;
    localparam logic [ADDR_W-1:0] A_WS     = 12'h24C;

    localparam int CTRL_CEN  = 0;
    localparam int CTRL_AUTO = 1;
    localparam int CTRL_RUN  = 8;

    typedef enum logic [2:0] {
        WK_NONE, WK_CNT_LO, WK_CNT_HI, WK_CMP_LO, WK_CMP_HI, WK_STEP, WK_CTRL
    } wkind_e;

    typedef struct packed {
        logic              vld;
        wkind_e            kind;
        logic [WORD_W-1:0] data;
    } wr_op_t;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  cmp;
        logic [WORD_W-1:0] step;
        logic              run;
        logic              cen;
        logic              auto_inc;
        logic              armed;
    } core_st_t;

    typedef struct packed {
        logic [1:0] cnt_ws;
        logic [3:0] ws;
        logic       ist;
        logic       ien;
    } flag_st_t;

endpackage

// File: rtl/cmptmr_wpipe.sv
module cmptmr_wpipe
    import cmptmr_pkg::*;
#(
    parameter int STAGES = 3
) (
    input  logic   clk,
    input  logic   rst_n,
    input  wr_op_t op_i,
    output wr_op_t op_o
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign op_o = op_i;
        end else begin : g_pipe
            wr_op_t pipe_d [STAGES];
            wr_op_t pipe_q [STAGES];

            always_comb begin
                pipe_d[0] = op_i;
                for (int i = 1; i < STAGES; i++) begin
                    pipe_d[i] = pipe_q[i-1];
                end
            end

            always_ff @(posedge clk) begin
                for (int i = 0; i < STAGES; i++) begin
                    if (!rst_n) pipe_q[i] <= '0;
                    else        pipe_q[i] <= pipe_d[i];
                end
            end

            assign op_o = pipe_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/cmptmr_core.sv
module cmptmr_core
    import cmptmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  wr_op_t            op_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CNT_W-1:0]  cmp_o,
    output logic [WORD_W-1:0] step_o,
    output logic              run_o,
    output logic              cen_o,
    output logic              auto_o,
    output logic              match_o
);

    core_st_t st_d, st_q;
    logic     hit;

    always_comb begin
        st_d = st_q;
        hit  = st_q.cen && st_q.armed && (st_q.cnt == st_q.cmp);

        if (st_q.run) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end

        if (hit) begin
            if (st_q.auto_inc) st_d.cmp   = st_q.cmp + {{WORD_W{1'b0}}, st_q.step};
            else               st_d.armed = 1'b0;
        end

        if (op_i.vld) begin
            unique case (op_i.kind)
                WK_CNT_LO: st_d.cnt = {st_q.cnt[CNT_W-1:WORD_W], op_i.data};
                WK_CNT_HI: st_d.cnt = {op_i.data, st_q.cnt[WORD_W-1:0]};
                WK_CMP_LO: begin
                    st_d.cmp   = {st_q.cmp[CNT_W-1:WORD_W], op_i.data};
                    st_d.armed = 1'b1;
                end
                WK_CMP_HI: begin
                    st_d.cmp   = {op_i.data, st_q.cmp[WORD_W-1:0]};
                    st_d.armed = 1'b1;
                end
                WK_STEP:   st_d.step = op_i.data;
                WK_CTRL: begin
                    st_d.run      = op_i.data[CTRL_RUN];
                    st_d.cen      = op_i.data[CTRL_CEN];
                    st_d.auto_inc = op_i.data[CTRL_AUTO];
                    st_d.armed    = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o   = st_q.cnt;
    assign cmp_o   = st_q.cmp;
    assign step_o  = st_q.step;
    assign run_o   = st_q.run;
    assign cen_o   = st_q.cen;
    assign auto_o  = st_q.auto_inc;
    assign match_o = hit;

endmodule

// File: rtl/cmptmr_flags.sv
module cmptmr_flags
    import cmptmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  wr_op_t     op_i,
    input  logic       match_i,
    input  logic [1:0] cnt_ws_clr_i,
    input  logic [3:0] ws_clr_i,
    input  logic       ist_clr_i,
    input  logic       ien_we_i,
    input  logic       ien_val_i,
    output logic [1:0] cnt_ws_o,
    output logic [3:0] ws_o,
    output logic       ist_o,
    output logic       ien_o,
    output logic       irq_o
);

    flag_st_t fl_d, fl_q;

    always_comb begin
        fl_d        = fl_q;
        fl_d.cnt_ws = fl_q.cnt_ws & ~cnt_ws_clr_i;
        fl_d.ws     = fl_q.ws & ~ws_clr_i;
        if (ist_clr_i) fl_d.ist = 1'b0;
        if (ien_we_i)  fl_d.ien = ien_val_i;

        if (op_i.vld) begin
            unique case (op_i.kind)
                WK_CNT_LO: fl_d.cnt_ws[0] = 1'b1;
                WK_CNT_HI: fl_d.cnt_ws[1] = 1'b1;
                WK_CMP_LO: fl_d.ws[0]     = 1'b1;
                WK_CMP_HI: fl_d.ws[1]     = 1'b1;
                WK_STEP:   fl_d.ws[2]     = 1'b1;
                WK_CTRL:   fl_d.ws[3]     = 1'b1;
                default: ;
            endcase
        end

        if (match_i) fl_d.ist = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign cnt_ws_o = fl_q.cnt_ws;
    assign ws_o     = fl_q.ws;
    assign ist_o    = fl_q.ist;
    assign ien_o    = fl_q.ien;
    assign irq_o    = fl_q.ist && fl_q.ien;

endmodule

// File: rtl/cmptmr_top.sv
module cmptmr_top
    import cmptmr_pkg::*;
#(
    parameter int SYNC_STAGES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq_o
);

    wr_op_t            wr_in, wr_out;
    logic [CNT_W-1:0]  cnt_val, cmp_val;
    logic [WORD_W-1:0] step_val;
    logic              run, cen, auto_inc, match;
    logic [1:0]        cnt_ws_clr, cnt_ws;
    logic [3:0]        ws_clr, ws;
    logic              ist_clr, ien_we, ist, ien;

    always_comb begin
        wr_in      = '0;
        cnt_ws_clr = '0;
        ws_clr     = '0;
        ist_clr    = 1'b0;
        ien_we     = 1'b0;
        if (bus_we) begin
            wr_in.vld  = 1'b1;
            wr_in.data = bus_wdata;
            unique case (bus_addr)
                A_CNT_LO: wr_in.kind = WK_CNT_LO;
                A_CNT_HI: wr_in.kind = WK_CNT_HI;
                A_CMP_LO: wr_in.kind = WK_CMP_LO;
                A_CMP_HI: wr_in.kind = WK_CMP_HI;
                A_STEP:   wr_in.kind = WK_STEP;
                A_CTRL:   wr_in.kind = WK_CTRL;
                default: begin
                    wr_in.vld  = 1'b0;
                    wr_in.kind = WK_NONE;
                end
            endcase
            cnt_ws_clr = (bus_addr == A_CNT_WS) ? bus_wdata[1:0] : 2'b00;
            ws_clr     = (bus_addr == A_WS) ? {bus_wdata[16], bus_wdata[2:0]} : 4'b0000;
            ist_clr    = (bus_addr == A_IST) && bus_wdata[0];
            ien_we     = (bus_addr == A_IEN);
        end
    end

    cmptmr_wpipe #(.STAGES(SYNC_STAGES)) u_wpipe (
        .clk   (clk),
        .rst_n (rst_n),
        .op_i  (wr_in),
        .op_o  (wr_out)
    );

    cmptmr_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_i    (wr_out),
        .cnt_o   (cnt_val),
        .cmp_o   (cmp_val),
        .step_o  (step_val),
        .run_o   (run),
        .cen_o   (cen),
        .auto_o  (auto_inc),
        .match_o (match)
    );

    cmptmr_flags u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_i         (wr_out),
        .match_i      (match),
        .cnt_ws_clr_i (cnt_ws_clr),
        .ws_clr_i     (ws_clr),
        .ist_clr_i    (ist_clr),
        .ien_we_i     (ien_we),
        .ien_val_i    (bus_wdata[0]),
        .cnt_ws_o     (cnt_ws),
        .ws_o         (ws),
        .ist_o        (ist),
        .ien_o        (ien),
        .irq_o        (irq_o)
    );

    always_comb begin
        unique case (bus_addr)
            A_CNT_LO: bus_rdata = cnt_val[WORD_W-1:0];
            A_CNT_HI: bus_rdata = cnt_val[CNT_W-1:WORD_W];
            A_CNT_WS: bus_rdata = {30'd0, cnt_ws};
            A_CMP_LO: bus_rdata = cmp_val[WORD_W-1:0];
            A_CMP_HI: bus_rdata = cmp_val[CNT_W-1:WORD_W];
            A_STEP:   bus_rdata = step_val;
            A_CTRL:   bus_rdata = {23'd0, run, 6'd0, auto_inc, cen};
            A_IST:    bus_rdata = {31'd0, ist};
            A_IEN:    bus_rdata = {31'd0, ien};
            A_WS:     bus_rdata = {15'd0, ws[3], 13'd0, ws[2:0]};
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cmptmr_chk.sv
module cmptmr_chk
    import cmptmr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WORD_W-1:0] bus_wdata,
    input wr_op_t            op,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  cmp,
    input logic [WORD_W-1:0] step,
    input logic              run,
    input logic              auto_inc,
    input logic              match,
    input logic [1:0]        cnt_ws,
    input logic              ist
);

    logic cnt_wr, cmp_wr;
    assign cnt_wr = op.vld && (op.kind == WK_CNT_LO || op.kind == WK_CNT_HI);
    assign cmp_wr = op.vld && (op.kind == WK_CMP_LO || op.kind == WK_CMP_HI);

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cnt_wr) |=> (cnt == $past(cnt) + 64'd1));

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> $stable(cnt));

    // R5
    cnt_ws_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op.vld && op.kind == WK_CNT_LO) |=> cnt_ws[0]);

    // R7
    hit_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> ist);

    // R8
    oneshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !auto_inc && !op.vld) |=> !match);

    // R9
    auto_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match && auto_inc && !cmp_wr) |=> (cmp == $past(cmp) + {32'd0, $past(step)}));

    // R10
    ist_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ist && !(bus_we && bus_addr == A_IST && bus_wdata[0])) |=> ist);

endmodule

bind cmptmr_top cmptmr_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .op        (wr_out),
    .cnt       (cnt_val),
    .cmp       (cmp_val),
    .step      (step_val),
    .run       (run),
    .auto_inc  (auto_inc),
    .match     (match),
    .cnt_ws    (cnt_ws),
    .ist       (ist)
);

// File: tb/cmptmr_tb.sv
`timescale 1ns/1ps
module cmptmr_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wd = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cmptmr_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wd), .bus_rdata(rdata), .irq_o(irq)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            checks++; fails++;
            $display("FAIL watchdog: act=%0d cycles exp<150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d, output int t);
        @(negedge clk); we = 1'b1; addr = a; wd = d;
        @(negedge clk); t = cyc; we = 1'b0;
    endtask

    task automatic wrn(logic [11:0] a, logic [31:0] d);
        int t;
        wr(a, d, t);
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] v);
        @(negedge clk); addr = a; #1 v = rdata;
    endtask

    task automatic rd64(logic [11:0] a, output logic [63:0] v);
        logic [31:0] lo, hi;
        rd(a, lo); rd(a + 12'h4, hi);
        v = {hi, lo};
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_irq(output int t);
        t = -1;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (irq) begin t = cyc; break; end
        end
    endtask

    function automatic logic [63:0] next_cmp(logic [63:0] c, logic [63:0] vf, logic [31:0] s);
        logic [63:0] n;
        n = (vf - c + {32'd0, s} - 64'd1) / {32'd0, s};
        return c + n * {32'd0, s};
    endfunction

    initial begin
        logic [31:0] v, h, r;
        logic [63:0] v64, c64, vf;
        int t, t0, t1, tc, te, d, s, hits;
        void'($urandom(32'd1234));

        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk("R1 irq", irq, 0);
        rd64(12'h100, v64); chk("R1 counter", v64, 0);
        rd(12'h240, r); chk("R1 ctrl", r, 0);
        rd(12'h24C, r); chk("R1 wstat", r, 0);
        rd(12'h110, r); chk("R1 cnt wstat", r, 0);
        // R12 unmapped read
        rd(12'h300, r); chk("R12 unmapped", r, 0);

        // R4 delayed effect, R2 half write
        v = $urandom;
        wr(12'h100, v, t);
        rd(12'h100, r); chk("R4 before +1", r, 0);
        rd(12'h100, r); chk("R4 before +2", r, 0);
        rd(12'h100, r); chk("R4 at +3", r, v);
        rd(12'h110, r); chk("R5 lo flag", r, 1);
        h = {4'h1, 28'($urandom)};
        wrn(12'h104, h); idle(3);
        rd64(12'h100, v64); chk("R2 both halves", v64, {h, v});
        rd(12'h110, r); chk("R5 both flags", r, 3);
        wrn(12'h110, 32'h1);
        rd(12'h110, r); chk("R5 clear bit0", r, 2);
        wrn(12'h110, 32'h2);
        rd(12'h110, r); chk("R5 clear bit1", r, 0);

        // R3 run with carry into the high word
        v = 32'hFFFF_FFFF - ($urandom % 6);
        wrn(12'h100, v); idle(3);
        wr(12'h240, 32'h100, t0);
        idle(10 + ($urandom % 50));
        wr(12'h240, 32'h0, t1);
        idle(4);
        rd64(12'h100, v64); chk("R3 count with carry", v64, {h, v} + 64'(t1 - t0));
        idle(10);
        rd64(12'h100, vf); chk("R3 hold when stopped", vf, v64);
        rd(12'h240, r); chk("R12 ctrl readback", r, 0);

        // R6 write-status for compare, step, control
        wrn(12'h200, 32'h0); wrn(12'h204, 32'h0); wrn(12'h208, 32'h5); idle(3);
        rd(12'h24C, r); chk("R6 all set", r, 32'h0001_0007);
        wrn(12'h24C, 32'h0001_0001);
        rd(12'h24C, r); chk("R6 partial clear", r, 32'h6);
        wrn(12'h24C, 32'h0001_0007);
        rd(12'h24C, r); chk("R6 full clear", r, 0);

        // R7, R8, R10: single-shot hits
        wrn(12'h248, 32'h1);
        for (int k = 0; k < 3; k++) begin
            rd64(12'h100, v64);
            d = 6 + int'($urandom % 40);
            c64 = v64 + 64'(d);
            wrn(12'h200, c64[31:0]); wrn(12'h204, c64[63:32]);
            wr(12'h240, 32'h101, tc);
            wait_irq(te);
            chk("R7 hit cycle", 64'(te), 64'(tc + 4 + d));
            rd(12'h244, r); chk("R10 status set", r, 1);
            wrn(12'h244, 32'h0);
            rd(12'h244, r); chk("R10 write 0 ignored", r, 1);
            wrn(12'h244, 32'h1);
            chk("R10 cleared", irq, 0);
            hits = 0;
            for (int i = 0; i < 60; i++) begin
                @(negedge clk); if (irq) hits++;
            end
            chk("R8 no rehit", 64'(hits), 0);
            rd64(12'h200, v64); chk("R8 compare unchanged", v64, c64);
            wrn(12'h240, 32'h0); idle(4);
        end

        // R9 periodic hits, R11 mask
        rd64(12'h100, v64);
        d = 8 + int'($urandom % 20);
        s = 12 + int'($urandom % 30);
        c64 = v64 + 64'(d);
        wrn(12'h208, 32'(s));
        wrn(12'h200, c64[31:0]); wrn(12'h204, c64[63:32]);
        wr(12'h240, 32'h103, tc);
        for (int k = 0; k < 4; k++) begin
            wait_irq(te);
            chk("R9 periodic hit cycle", 64'(te), 64'(tc + 4 + d + k * s));
            wrn(12'h244, 32'h1);
            chk("R10 cleared periodic", irq, 0);
        end
        rd(12'h240, r); chk("R12 ctrl bits", r, 32'h103);
        wrn(12'h248, 32'h0);
        idle(s + 2);
        rd(12'h244, r); chk("R11 status while masked", r, 1);
        chk("R11 irq masked", irq, 0);
        wrn(12'h248, 32'h1);
        chk("R11 irq unmasked", irq, 1);
        wrn(12'h240, 32'h0); idle(4);
        rd64(12'h100, vf);
        rd64(12'h200, v64);
        chk("R9 final compare", v64, next_cmp(c64, vf, 32'(s)));
        wrn(12'h240, 32'hFFFF_FEFC); idle(3);
        rd(12'h240, r); chk("R12 unused ctrl bits", r, 0);

        done = 1;
        summary();
        $finish;
    end

endmodule